// File: doc/BRIEF.md
# Transmit Start Threshold Controller

This block sequences the transmit side of a 10/100 Ethernet controller. A host start bit moves it from the stopped state into a running state. The first thing it does when running is ask for a transmit descriptor. It then looks at who owns that descriptor. If the host still owns it, the process parks in a suspended state and raises a sticky buffer-unavailable flag. The host can restart it with a poll pulse. If the device owns it, the block lets the DMA move packet bytes into the transmit FIFO.

The block tells the serializer to start once the FIFO holds more bytes than a programmable start level. A short frame whose end marker has already landed in the FIFO also starts it. The start level comes from a 2-bit code, and the code means different byte counts at 10 Mb/s and at 100 Mb/s. When the host clears the start bit, any frame already being filled or sent completes before the process stops.

Top module: `txl_launch_ctrl`

## Requirements
- R1: After a synchronous reset, `proc_state` is 0 (stopped), `desc_req`, `move_en` and `tx_go` are low, and `unavail_flag` is low. The state codes are: 0 stopped, 1 descriptor fetch, 2 suspended, 3 filling, 4 sending.
- R2: With `speed_100`=1, `thr_code` 0, 1 and 2 give start levels of 128, 256 and 512 bytes.
- R3: With `speed_100`=0, `thr_code` 0, 1 and 2 give start levels of 72, 96 and 128 bytes.
- R4: `thr_code`=3 acts as the largest defined level for the current speed: 512 at 100 Mb/s and 128 at 10 Mb/s.
- R5: While filling, the block moves to sending only when `fifo_level` is strictly greater than the start level. A level equal to the start level keeps it filling.
- R6: When `run_cmd` is high in the stopped state, the next cycle is descriptor fetch, with `desc_req` high.
- R7: In fetch, `desc_valid` with `desc_host_owned`=1 moves the block to suspended and sets `unavail_flag` in the same cycle.
- R8: In fetch, `desc_valid` with `desc_host_owned`=0 moves the block to filling. `move_en` stays high through filling and sending.
- R9: Clearing `run_cmd` during filling or sending does not end the frame. The block reaches stopped only on the cycle after `tx_done`, and it does not request another descriptor.
- R10: While filling, `eof_written`=1 starts the send whatever the FIFO level.
- R11: In suspended with `run_cmd` high, a `poll_pulse` returns the block to descriptor fetch.
- R12: `unavail_flag` stays set until `unavail_clr` is high for a cycle. A new set in that same cycle takes priority over the clear.
- R13: Clearing `run_cmd` while in fetch or suspended moves the block to stopped on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_cmd | input | 1 | Host start/stop bit |
| poll_pulse | input | 1 | Host transmit-poll request |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| thr_code | input | 2 | Start-level code |
| desc_valid | input | 1 | Fetched descriptor ownership is valid |
| desc_host_owned | input | 1 | 1 when the host owns the descriptor |
| fifo_level | input | LVL_W | Bytes currently held in the transmit FIFO |
| eof_written | input | 1 | End-of-frame marker is in the FIFO |
| tx_done | input | 1 | Serializer finished the current frame |
| unavail_clr | input | 1 | Write-one-to-clear for the status flag |
| desc_req | output | 1 | Descriptor fetch request |
| move_en | output | 1 | DMA may move packet data into the FIFO |
| tx_go | output | 1 | Serializer may transmit |
| unavail_flag | output | 1 | Sticky buffer-unavailable status |
| proc_state | output | 3 | Current process state code |

## Verification
The bench builds the block with the default `LVL_W` of 11. An 11-bit level reaches 513, one byte past the largest start level, so it can test both the equal and the exceeding level for all eight speed and code pairs, including the reserved code. A behavioural reference model runs alongside the design and is compared on every clock. Directed sequences cover clearing the start bit at each state and a flag clear that lands in the same cycle as a new set.

// File: rtl/txl_pkg.sv
package txl_pkg;

    typedef enum logic [2:0] {
        TXS_IDLE  = 3'd0,
        TXS_FETCH = 3'd1,
        TXS_HOLD  = 3'd2,
        TXS_FILL  = 3'd3,
        TXS_SEND  = 3'd4
    } txs_e;

    typedef struct packed {
        logic       fast;
        logic [1:0] code;
    } thr_cfg_t;

    typedef struct packed {
        logic run;
        logic poll;
        logic desc_valid;
        logic desc_host;
        logic launch_ok;
        logic done;
    } seq_in_t;

    localparam int unsigned THR_W = 10;

    localparam logic [THR_W-1:0] FAST_L0 = 10'd128;
    localparam logic [THR_W-1:0] FAST_L1 = 10'd256;
    localparam logic [THR_W-1:0] FAST_L2 = 10'd512;
    localparam logic [THR_W-1:0] SLOW_L0 = 10'd72;
    localparam logic [THR_W-1:0] SLOW_L1 = 10'd96;
    localparam logic [THR_W-1:0] SLOW_L2 = 10'd128;

    // Reserved code 3 maps onto the top defined level of the chosen speed.
    function automatic logic [THR_W-1:0] pick_level(input logic fast, input logic [1:0] code);
        logic [THR_W-1:0] lvl;
        unique case (code)
            2'd0:    lvl = fast ? FAST_L0 : SLOW_L0;
            2'd1:    lvl = fast ? FAST_L1 : SLOW_L1;
            default: lvl = fast ? FAST_L2 : SLOW_L2;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/txl_threshold.sv
module txl_threshold
    import txl_pkg::*;
#(
    parameter int LVL_W = 11
) (
    input  thr_cfg_t         cfg_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             eof_i,
    output logic             launch_ok_o
);
    localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [THR_W-1:0] level_sel;
    logic [CMP_W-1:0] level_ext;
    logic [CMP_W-1:0] thr_ext;
    logic [THR_W-1:0] slow_sel;
    logic [THR_W-1:0] fast_sel;

    always_comb begin
        level_sel = pick_level(cfg_i.fast, cfg_i.code);
        slow_sel  = pick_level(1'b0, cfg_i.code);
        fast_sel  = pick_level(1'b1, cfg_i.code);
        level_ext = CMP_W'(level_i);
        thr_ext   = CMP_W'(level_sel);
        launch_ok_o = (level_ext > thr_ext) || eof_i;
    end

    // R3/R2: the 10 Mb/s level never exceeds the 100 Mb/s level for a code.
    always_comb begin
        p_slow_le_fast_r3: assert (slow_sel <= fast_sel);
    end

endmodule

// File: rtl/txl_status.sv
module txl_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/txl_seq.sv
module txl_seq
    import txl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_in_t in_i,
    output txs_e    state_o,
    output logic    set_unavail_o
);
    txs_e state_q;
    txs_e state_d;

    always_comb begin
        state_d       = state_q;
        set_unavail_o = 1'b0;
        unique case (state_q)
            TXS_IDLE: begin
                if (in_i.run) state_d = TXS_FETCH;
            end
            TXS_FETCH: begin
                if (!in_i.run) begin
                    state_d = TXS_IDLE;
                end else if (in_i.desc_valid) begin
                    if (in_i.desc_host) begin
                        state_d       = TXS_HOLD;
                        set_unavail_o = 1'b1;
                    end else begin
                        state_d = TXS_FILL;
                    end
                end
            end
            TXS_HOLD: begin
                if (!in_i.run)       state_d = TXS_IDLE;
                else if (in_i.poll)  state_d = TXS_FETCH;
            end
            TXS_FILL: begin
                if (in_i.launch_ok) state_d = TXS_SEND;
            end
            TXS_SEND: begin
                if (in_i.done) state_d = in_i.run ? TXS_FETCH : TXS_IDLE;
            end
            default: state_d = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TXS_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    p_frame_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXS_SEND && !in_i.done) |=> state_q == TXS_SEND);
    p_fill_waits_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXS_FILL && !in_i.launch_ok) |=> state_q == TXS_FILL);
    p_host_suspends_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXS_FETCH && in_i.run && in_i.desc_valid && in_i.desc_host)
        |=> state_q == TXS_HOLD);
    p_stop_idle_r13: assert property (@(posedge clk) disable iff (rst)
        ((state_q == TXS_FETCH || state_q == TXS_HOLD) && !in_i.run)
        |=> state_q == TXS_IDLE);
    p_start_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXS_IDLE && in_i.run) |=> state_q == TXS_FETCH);

endmodule

// File: rtl/txl_launch_ctrl.sv
module txl_launch_ctrl
    import txl_pkg::*;
#(
    parameter int LVL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_cmd,
    input  logic             poll_pulse,
    input  logic             speed_100,
    input  logic [1:0]       thr_code,
    input  logic             desc_valid,
    input  logic             desc_host_owned,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             eof_written,
    input  logic             tx_done,
    input  logic             unavail_clr,
    output logic             desc_req,
    output logic             move_en,
    output logic             tx_go,
    output logic             unavail_flag,
    output logic [2:0]       proc_state
);
    thr_cfg_t cfg;
    seq_in_t  seq_in;
    txs_e     state;
    logic     launch_ok;
    logic     set_unavail;

    assign cfg = '{fast: speed_100, code: thr_code};

    txl_threshold #(.LVL_W(LVL_W)) u_thr (
        .cfg_i       (cfg),
        .level_i     (fifo_level),
        .eof_i       (eof_written),
        .launch_ok_o (launch_ok)
    );

    assign seq_in = '{run: run_cmd, poll: poll_pulse, desc_valid: desc_valid,
                      desc_host: desc_host_owned, launch_ok: launch_ok, done: tx_done};

    txl_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .in_i          (seq_in),
        .state_o       (state),
        .set_unavail_o (set_unavail)
    );

    txl_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_unavail),
        .clr_i  (unavail_clr),
        .flag_o (unavail_flag)
    );

    assign desc_req   = (state == TXS_FETCH);
    assign move_en    = (state == TXS_FILL) || (state == TXS_SEND);
    assign tx_go      = (state == TXS_SEND);
    assign proc_state = state;

    p_go_needs_launch_r10: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_FILL && !launch_ok) |=> !tx_go);
    p_move_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_FETCH && run_cmd && desc_valid && !desc_host_owned) |=> move_en);

endmodule

// File: tb/txl_launch_ctrl_tb.sv
`timescale 1ns/1ps
module txl_launch_ctrl_tb;
    localparam int LVL_W = 11;

    logic clk = 1'b0;
    logic rst, run_cmd, poll_pulse, speed_100, desc_valid, desc_host_owned;
    logic eof_written, tx_done, unavail_clr;
    logic [1:0] thr_code;
    logic [LVL_W-1:0] fifo_level;
    logic desc_req, move_en, tx_go, unavail_flag;
    logic [2:0] proc_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int m_st = 0;
    int m_flag = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    txl_launch_ctrl #(.LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst(rst), .run_cmd(run_cmd), .poll_pulse(poll_pulse),
        .speed_100(speed_100), .thr_code(thr_code), .desc_valid(desc_valid),
        .desc_host_owned(desc_host_owned), .fifo_level(fifo_level),
        .eof_written(eof_written), .tx_done(tx_done), .unavail_clr(unavail_clr),
        .desc_req(desc_req), .move_en(move_en), .tx_go(tx_go),
        .unavail_flag(unavail_flag), .proc_state(proc_state)
    );

    function automatic int ref_level(input logic fast, input logic [1:0] code);
        int t;
        if (fast) begin
            case (code)
                2'd0: t = 128;
                2'd1: t = 256;
                default: t = 512;
            endcase
        end else begin
            case (code)
                2'd0: t = 72;
                2'd1: t = 96;
                default: t = 128;
            endcase
        end
        return t;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        int nxt;
        bit setf;
        nxt = m_st;
        setf = 0;
        if (rst) begin
            m_st = 0;
            m_flag = 0;
        end else begin
            if (m_st == 0 && run_cmd) nxt = 1;
            if (m_st == 1) begin
                if (!run_cmd) nxt = 0;
                else if (desc_valid && desc_host_owned) begin nxt = 2; setf = 1; end
                else if (desc_valid) nxt = 3;
            end
            if (m_st == 2) begin
                if (!run_cmd) nxt = 0;
                else if (poll_pulse) nxt = 1;
            end
            if (m_st == 3 && (int'(fifo_level) > ref_level(speed_100, thr_code) || eof_written)) nxt = 4;
            if (m_st == 4 && tx_done) nxt = run_cmd ? 1 : 0;
            if (setf) m_flag = 1;
            else if (unavail_clr) m_flag = 0;
            m_st = nxt;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        check({phase, " model state"}, int'(proc_state), m_st);
        check({phase, " model flag"}, int'(unavail_flag), m_flag);
        check({phase, " model desc_req"}, int'(desc_req), int'(m_st == 1));
        check({phase, " model move_en"}, int'(move_en), int'(m_st == 3 || m_st == 4));
        check({phase, " model tx_go"}, int'(tx_go), int'(m_st == 4));
    endtask

    task automatic to_fill();
        desc_valid = 1; desc_host_owned = 0;
        cyc();
        desc_valid = 0;
    endtask

    task automatic level_case(input logic fast, input logic [1:0] code, input int lvl, input string tag);
        phase = tag;
        speed_100 = fast; thr_code = code;
        fifo_level = LVL_W'(lvl);
        cyc();
        check({tag, " equal level keeps filling (R5)"}, int'(proc_state), 3);
        fifo_level = LVL_W'(lvl + 1);
        cyc();
        check({tag, " level above start sends"}, int'(proc_state), 4);
        fifo_level = '0; tx_done = 1;
        cyc();
        tx_done = 0;
        check({tag, " back to fetch"}, int'(proc_state), 1);
        to_fill();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; run_cmd = 0; poll_pulse = 0; speed_100 = 1; thr_code = 0;
        desc_valid = 0; desc_host_owned = 0; fifo_level = '0; eof_written = 0;
        tx_done = 0; unavail_clr = 0;
        repeat (3) cyc();
        rst = 0;
        cyc();
        check("R1 reset state", int'(proc_state), 0);
        check("R1 reset flag", int'(unavail_flag), 0);
        check("R1 reset tx_go", int'(tx_go), 0);

        phase = "R6";
        run_cmd = 1;
        cyc();
        check("R6 fetch after start", int'(desc_req), 1);

        phase = "R8";
        to_fill();
        check("R8 device-owned fills", int'(move_en), 1);

        level_case(1, 2'd0, 128, "R2 fast c0");
        level_case(1, 2'd1, 256, "R2 fast c1");
        level_case(1, 2'd2, 512, "R2 fast c2");
        level_case(1, 2'd3, 512, "R4 fast c3");
        level_case(0, 2'd0, 72,  "R3 slow c0");
        level_case(0, 2'd1, 96,  "R3 slow c1");
        level_case(0, 2'd2, 128, "R3 slow c2");
        level_case(0, 2'd3, 128, "R4 slow c3");

        phase = "R10";
        speed_100 = 1; thr_code = 2'd2; fifo_level = LVL_W'(5);
        cyc();
        check("R10 short frame waits", int'(proc_state), 3);
        eof_written = 1;
        cyc();
        eof_written = 0;
        check("R10 eof launches", int'(tx_go), 1);

        phase = "R9";
        run_cmd = 0;
        repeat (3) cyc();
        check("R9 frame continues after stop", int'(proc_state), 4);
        check("R9 data still moving", int'(move_en), 1);
        tx_done = 1;
        cyc();
        tx_done = 0;
        check("R9 stopped after done", int'(proc_state), 0);
        cyc();
        check("R9 no new fetch", int'(desc_req), 0);

        phase = "R7";
        run_cmd = 1;
        cyc();
        desc_valid = 1; desc_host_owned = 1;
        cyc();
        desc_valid = 0;
        check("R7 host-owned suspends", int'(proc_state), 2);
        check("R7 flag set", int'(unavail_flag), 1);
        phase = "R12";
        repeat (4) cyc();
        check("R12 flag sticky", int'(unavail_flag), 1);

        phase = "R11";
        poll_pulse = 1;
        cyc();
        poll_pulse = 0;
        check("R11 poll refetches", int'(proc_state), 1);
        phase = "R12";
        desc_valid = 1; desc_host_owned = 1; unavail_clr = 1;
        cyc();
        desc_valid = 0; unavail_clr = 0;
        check("R12 set wins over clear", int'(unavail_flag), 1);
        unavail_clr = 1;
        cyc();
        unavail_clr = 0;
        check("R12 write-one clears", int'(unavail_flag), 0);
        cyc();
        check("R12 stays clear", int'(unavail_flag), 0);

        phase = "R13";
        run_cmd = 0;
        cyc();
        check("R13 stop from suspend", int'(proc_state), 0);
        run_cmd = 1;
        cyc();
        check("R13 refetch", int'(proc_state), 1);
        run_cmd = 0;
        cyc();
        check("R13 stop from fetch", int'(proc_state), 0);
        repeat (2) cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule